// File: doc/BRIEF.md
# General purpose I/O port with pin change interrupt

This block is one 8-pin slice of a general purpose I/O port. Software sets up each pin through a small register bank. The settings cover direction, output source, pull-up, analog use and change-interrupt enable. The block drives the pad controls from those settings and returns the synchronised pin levels through a read register. The same synchronised levels also go to on-chip peripherals.

The drive register has two meanings, chosen by the pin's direction. On an output pin it holds the value driven onto the pad. On an input pin it enables the pull-up.

Each enabled pin has a sticky pending flag. The flag is set whenever the synchronised level differs from the snapshot taken at the last read of the level register. Reading the level register clears every flag and retakes the snapshot. The interrupt output is the OR of the pending flags of the enabled pins.

Top module: `gpio_port`

## Requirements
- R1: After reset, every configuration register reads 0, no pad is driven, no pull-up is on, every input buffer is on and the interrupt is low.
- R2: Register addresses are 0 direction, 1 drive, 2 output source, 3 analog, 4 change-interrupt enable and 5 pin level (read only). Configuration writes read back unchanged. A direction bit of 1 sets that pin's `pad_oe`.
- R3: On an output pin, an output-source bit of 0 drives the drive-register bit onto `pad_out`, and a bit of 1 drives the matching `periph_out` bit. Input pins drive `pad_out` low.
- R4: On an input pin, the drive bit enables the pull-up (`pad_pu`). An output pin never has its pull-up on.
- R5: An analog bit of 1 turns the pin's input buffer off (`pad_ie` = 0). That pin then reads 0 in the level register and on `sync_in`.
- R6: The level register and `sync_in` show `pad_in` through a two-flop synchroniser. A new pad value is visible after the second rising clock edge and not after the first.
- R7: A level change on a pin whose enable bit is set raises `irq`. A change on a pin whose enable bit is clear does not.
- R8: Reading the level register clears all pending change flags, so `irq` is low in the following cycle.
- R9: A pin that changes and then changes back before the level register is read still leaves its change pending.
- R10: A pin set to analog never raises a change interrupt, even when its pad toggles.
- R11: A synchronised change that lands in the same cycle as a level read is not lost. It becomes pending one cycle later.
- R12: `irq` is the OR of pending flags masked by the enable bits. Clearing the enable bit of the only pending pin drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| periph_out | input | 8 | Peripheral output value for each pin |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_ie | output | 8 | Pad input buffer enable |
| sync_in | output | 8 | Synchronised pin levels for peripherals |
| irq | output | 1 | Port change interrupt |

## Verification
The bench drives pads at known points against the clock edges. It checks the level one edge after a change, where a single-flop or missing synchroniser would already show the new value. It also checks the level two edges after the change, where a synchroniser that was too deep would still show the old one.

The bench toggles a pin and restores it before any read. A design that compares only consecutive samples would lose that change, and the bench would see `irq` stay low.

The bench times a pad change to land on the same edge that clears the flags through a read. A design that lets the clear win and also updates the snapshot late would drop the event for good.

The bench toggles analog pins and pins without interrupt enable. A design that leaks analog or masked pins into the pending logic would raise `irq` there.

// File: rtl/gpio_pkg.sv
// Shared register map and widths for the GPIO port slice.
package gpio_pkg;
    localparam int ADDR_W = 3;

    // Register addresses; software drivers depend on these values.
    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 3'd0,
        REG_DRIVE = 3'd1,
        REG_SRC   = 3'd2,
        REG_ANA   = 3'd3,
        REG_IEN   = 3'd4,
        REG_LEVEL = 3'd5
    } gpio_reg_e;
endpackage

// File: rtl/gpio_regs.sv
// Configuration register bank with combinational read mux.
// Assumes single-cycle write strobes; the level register is read only.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  level,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  drive_q,
    output logic [WIDTH-1:0]  src_q,
    output logic [WIDTH-1:0]  ana_q,
    output logic [WIDTH-1:0]  ien_q
);
    // Capture configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            drive_q <= '0;
            src_q   <= '0;
            ana_q   <= '0;
            ien_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_DIR:   dir_q   <= wdata;
                REG_DRIVE: drive_q <= wdata;
                REG_SRC:   src_q   <= wdata;
                REG_ANA:   ana_q   <= wdata;
                REG_IEN:   ien_q   <= wdata;
                default:   ;
            endcase
        end
    end

    // Select read data by address.
    always_comb begin
        case (addr)
            REG_DIR:   rdata = dir_q;
            REG_DRIVE: rdata = drive_q;
            REG_SRC:   rdata = src_q;
            REG_ANA:   rdata = ana_q;
            REG_IEN:   rdata = ien_q;
            REG_LEVEL: rdata = level;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_sync.sv
// Multi-flop synchroniser for asynchronous pad inputs, one chain per pin.
// Assumes STAGES >= 2; output is reset to 0.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw pad.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage resamples its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_padmux.sv
// Per-pin pad control: output source select, enable, pull-up and input gate.
// Assumes all configuration inputs are register outputs.
module gpio_padmux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] drive,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] ana,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] synced,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] pad_ie,
    output logic [WIDTH-1:0] level
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Drive register bit doubles as pull-up enable on inputs.
        always_comb begin
            pad_oe[i]  = dir[i];
            pad_out[i] = dir[i] & (src[i] ? periph_out[i] : drive[i]);
            pad_pu[i]  = ~dir[i] & drive[i];
            pad_ie[i]  = ~ana[i];
            level[i]   = synced[i] & ~ana[i];
        end
    end
endmodule

// File: rtl/gpio_chg.sv
// Pin change detector: sticky pending flags against a snapshot taken on level read.
// Assumes 'level' is already synchronised; analog pins are masked out.
module gpio_chg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] ien,
    input  logic [WIDTH-1:0] ana,
    input  logic             snap_read,
    output logic             irq
);
    logic [WIDTH-1:0] snap_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] diff;

    assign diff = (level ^ snap_q) & ien & ~ana;

    // Snapshot the level on every read of the level register.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_read) snap_q <= level;
    end

    // Set flags on difference, clear all on read.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= '0;
        else if (snap_read) pend_q <= '0;
        else                pend_q <= pend_q | diff;
    end

    assign irq = |(pend_q & ien);
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port slice: register bank, synchroniser, pad mux, change detect.
// Assumes a synchronous bus; pad_in is asynchronous to clk.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic [WIDTH-1:0]  periph_out,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    output logic [WIDTH-1:0]  pad_ie,
    output logic [WIDTH-1:0]  sync_in,
    output logic              irq
);
    logic [WIDTH-1:0] dir_q, drive_q, src_q, ana_q, ien_q;
    logic [WIDTH-1:0] synced, level;
    logic             level_read;

    assign level_read = rd_en && (addr == REG_LEVEL);
    assign sync_in    = level;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .level(level), .rdata(rdata), .dir_q(dir_q), .drive_q(drive_q),
        .src_q(src_q), .ana_q(ana_q), .ien_q(ien_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(synced)
    );

    gpio_padmux #(.WIDTH(WIDTH)) u_mux (
        .dir(dir_q), .drive(drive_q), .src(src_q), .ana(ana_q),
        .periph_out(periph_out), .synced(synced), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_ie(pad_ie), .level(level)
    );

    gpio_chg #(.WIDTH(WIDTH)) u_chg (
        .clk(clk), .rst_n(rst_n), .level(level), .ien(ien_q), .ana(ana_q),
        .snap_read(level_read), .irq(irq)
    );
endmodule

// File: rtl/gpio_port_chk.sv
// Protocol checker for gpio_port, attached by bind.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wdata,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic [WIDTH-1:0]  pad_ie,
    input logic [WIDTH-1:0]  ien,
    input logic              irq
);
    // R2: direction write reaches pad_oe one cycle later
    p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> pad_oe == $past(wdata));

    // R4: pull-up never on for a driven pin
    p_pu_inputs_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R5: analog write gates input buffers next cycle
    p_ana_gates_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_ANA) |=> pad_ie == ~$past(wdata));

    // R7: no interrupt without an enabled pin
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien != '0);

    // R8: level read clears the interrupt
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_LEVEL) |=> !irq);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_ie(pad_ie),
    .ien(ien_q), .irq(irq)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, periph_out = '0, pad_in = '0;
    logic [7:0] rdata, pad_out, pad_oe, pad_pu, pad_ie, sync_in;
    logic       irq;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .periph_out(periph_out), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_ie(pad_ie),
        .sync_in(sync_in), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full cycle: returns on the falling edge.
    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    // Read combinationally at the falling edge, then complete the cycle.
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #0.1 d = rdata;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 8'h00);
        end
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        check("R1 ie", pad_ie, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_output();
        logic [7:0] v;
        periph_out = 8'h01;
        wr(3'd0, 8'h0F);
        wr(3'd1, 8'hA5);
        wr(3'd2, 8'h03);
        rd(3'd0, v); check("R2 dir readback", v, 8'h0F);
        rd(3'd1, v); check("R2 drive readback", v, 8'hA5);
        rd(3'd2, v); check("R2 src readback", v, 8'h03);
        check("R2 oe", pad_oe, 8'h0F);
        check("R3 pad_out", pad_out, 8'h05);
        periph_out = 8'h02;
        #0.1 check("R3 periph follow", pad_out, 8'h06);
        check("R4 pullup", pad_pu, 8'hA0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        pad_in = 8'h3C;
        tick();
        rd(3'd5, v);        // sampled before second edge
        check("R6 not yet", v, 8'h00);
        rd(3'd5, v);
        check("R6 level", v, 8'h3C);
        check("R6 sync_in", sync_in, 8'h3C);
    endtask

    task automatic t_analog();
        logic [7:0] v;
        wr(3'd3, 8'h0C);
        wr(3'd4, 8'hFF);
        check("R5 ie", pad_ie, 8'hF3);
        rd(3'd5, v); check("R5 level", v, 8'h30);
        check("R5 sync_in", sync_in, 8'h30);
        pad_in = 8'h30; tick(3);
        pad_in = 8'h3C; tick(4);
        check("R10 analog toggle", {7'd0, irq}, 8'h00);
        pad_in = 8'h30; tick(4);
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h00);
        rd(3'd5, v);
    endtask

    task automatic t_change();
        logic [7:0] v;
        wr(3'd4, 8'h01);
        pad_in = 8'h10; tick(4);
        check("R7 masked pin", {7'd0, irq}, 8'h00);
        pad_in = 8'h11; tick(4);
        check("R7 enabled pin", {7'd0, irq}, 8'h01);
        rd(3'd5, v);
        check("R8 level", v, 8'h11);
        check("R8 cleared", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_toggle_back();
        logic [7:0] v;
        pad_in = 8'h10; tick(3);
        pad_in = 8'h11; tick(4);
        check("R9 toggle back", {7'd0, irq}, 8'h01);
        rd(3'd5, v);
        check("R9 clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        pad_in = 8'h10;
        tick();             // first stage has it
        rd(3'd5, v);        // second stage updates at the clearing edge
        check("R11 old level", v, 8'h11);
        check("R11 clear edge", {7'd0, irq}, 8'h00);
        tick();
        check("R11 kept", {7'd0, irq}, 8'h01);
        rd(3'd5, v);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(3'd4, 8'h03);
        pad_in = 8'h12; tick(4);
        check("R12 irq set", {7'd0, irq}, 8'h01);
        wr(3'd4, 8'h01);
        check("R12 masked", {7'd0, irq}, 8'h00);
        rd(3'd5, v);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_output();
        t_sync();
        t_analog();
        t_change();
        t_toggle_back();
        t_same_cycle();
        t_mask();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule